// File: doc/BRIEF.md
# Periodic Loaded Battery Test Sequencer

This block schedules load tests of a backup cell. While the supply is valid, it switches a test load onto the cell for a fixed window and samples a comparator flag that reports whether the loaded cell sits below its threshold. It samples that flag on the clock edge that closes the window. A low reading sets a latched warning. The latch drives an open-drain enable, where 1 pulls the active-low warning line down. A good cell leaves the warning unchanged. Every interval is a parameterised count of clock cycles.

While the warning is clear, tests are spaced by a long interval. While it is set, tests are spaced by a short interval, so that a cell swap is caught quickly. A passing routine test cannot clear the warning on its own. The warning clears only after one of two events, followed by a passing test:
- the cell was removed for at least a minimum gap and then reattached;
- the supply has just come up (the first test after power-up).

A supply failure stops all testing at once. It abandons any test in progress without sampling it, and it keeps the latched warning.

Top module: `batt_test_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards as long as `supply_ok` stays low, `load_en` and `warn_pull_en` are 0.
- R2: `load_en` rises on the clock edge that comes REC_CYC edges after the first edge that samples `supply_ok` high. That edge starts the power-up test.
- R3: Every load window holds `load_en` high for exactly LOAD_CYC cycles. The battery is sampled on the edge that ends the window.
- R4: If `batt_low` is 1 at the sampling edge, `warn_pull_en` is 1 from that edge on, in the same cycle in which `load_en` falls.
- R5: When the sample leaves the warning at 0, `load_en` stays low for NORM_CYC cycles before the next window.
- R6: When the sample leaves the warning at 1, `load_en` stays low for WARN_CYC cycles before the next window.
- R7: A passing routine test does not clear a set warning unless a qualified reattach came before it.
- R8: A reattach is qualified when `batt_present` rises after at least GAP_CYC edges that sampled it low. While the warning is set and the block waits, a qualified reattach starts a load window on that same edge, and a passing sample in that window clears the warning. A reattach after a shorter absence changes nothing.
- R9: When `supply_ok` is 0 at an edge, `load_en` is 0 after that edge. A test in progress is dropped without updating the warning, and `warn_pull_en` keeps its value for as long as the supply stays low.
- R10: A passing power-up test clears a warning that was carried through a supply loss.
- R11: Between load windows, neither `batt_low` nor the removal of a cell while no warning is set has any effect on `warn_pull_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Main supply valid |
| batt_low | input | 1 | Comparator: loaded cell below threshold |
| batt_present | input | 1 | Cell attached |
| load_en | output | 1 | Connects the test load to the cell |
| warn_pull_en | output | 1 | 1 pulls the active-low warning line low |

## Verification
Two events can land on the same clock edge: the sample that closes a load window, and a supply failure. The bench starts a test with a low cell and drops `supply_ok` in the last cycle of the load window, so that the sampling edge also sees the failure. The check passes only if `load_en` falls and the warning stays clear: the failure must take precedence and discard the sample. The bench then restores the supply and checks that a new power-up test runs with the full recovery delay.

// File: rtl/bts_pkg.sv
// Shared types for the battery test sequencer.
package bts_pkg;
    // Sequencer phases: supply off, post-power-up recovery, idle interval, load applied
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RECOV = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LOAD  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/bts_timer.sv
// Down-counter shared by all sequencer phases.
// A start pulse loads len-1; done is high in the final cycle of a phase of
// len cycles. Assumes len >= 1.
module bts_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero and hold there
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= len - 1'b1;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/bts_gap_watch.sv
// Detach-gap watcher. Counts the edges on which the cell reads absent
// (saturating) and flags a reattach whose preceding absence lasted at
// least GAP_CYC edges. The flag is combinational on the rising edge of
// batt_present.
module bts_gap_watch #(
    parameter int GAP_CYC = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_present,
    output logic reattach_ok
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(GAP_CYC);

    logic          present_q;
    logic [GW-1:0] gap_cnt;

    // Track previous presence and the length of the current absence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b1;
            gap_cnt   <= '0;
        end else begin
            present_q <= batt_present;
            if (batt_present)          gap_cnt <= '0;
            else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign reattach_ok = batt_present && !present_q && (gap_cnt == GAP_MAX);
endmodule

// File: rtl/bts_ctrl.sv
// Sequencer control. Walks off -> recovery -> load -> wait -> load ...,
// samples the comparator on the last load cycle and keeps the warning latch.
// The warning clears only on a passing sample that follows a power-up or a
// qualified reattach. A supply failure overrides every other transition.
module bts_ctrl
    import bts_pkg::*;
#(
    parameter int REC_CYC  = 20,
    parameter int LOAD_CYC = 8,
    parameter int NORM_CYC = 200,
    parameter int WARN_CYC = 40,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          batt_low,
    input  logic          reattach_ok,
    input  logic          tmr_done,
    output logic          tmr_start,
    output logic [CW-1:0] tmr_len,
    output logic          load_en,
    output logic          warn
);
    localparam logic [CW-1:0] L_REC  = CW'(REC_CYC);
    localparam logic [CW-1:0] L_LOAD = CW'(LOAD_CYC);
    localparam logic [CW-1:0] L_NORM = CW'(NORM_CYC);
    localparam logic [CW-1:0] L_WARN = CW'(WARN_CYC);

    seq_state_t state, state_n;
    logic       pu_pend, pu_pend_n;
    logic       fresh, fresh_n;
    logic       warn_n;
    logic       smp;

    // Next-state, timer command and sample strobe
    always_comb begin
        state_n   = state;
        tmr_start = 1'b0;
        tmr_len   = L_LOAD;
        smp       = 1'b0;
        if (!supply_ok) begin
            state_n = ST_OFF;
        end else begin
            case (state)
                ST_OFF: begin
                    state_n   = ST_RECOV;
                    tmr_start = 1'b1;
                    tmr_len   = L_REC;
                end
                ST_RECOV: if (tmr_done) begin
                    state_n   = ST_LOAD;
                    tmr_start = 1'b1;
                end
                ST_LOAD: if (tmr_done) begin
                    smp       = 1'b1;
                    state_n   = ST_WAIT;
                    tmr_start = 1'b1;
                    tmr_len   = warn_n ? L_WARN : L_NORM;
                end
                ST_WAIT: if (tmr_done || (reattach_ok && warn)) begin
                    state_n   = ST_LOAD;
                    tmr_start = 1'b1;
                end
                default: state_n = ST_OFF;
            endcase
        end
    end

    // Warning, power-up and replacement flags for the next cycle
    always_comb begin
        warn_n    = warn;
        fresh_n   = fresh;
        pu_pend_n = pu_pend;
        if (smp) begin
            if (batt_low)               warn_n = 1'b1;
            else if (pu_pend || fresh)  warn_n = 1'b0;
            fresh_n   = 1'b0;
            pu_pend_n = 1'b0;
        end else begin
            if (reattach_ok && warn) fresh_n = 1'b1;
            if (state == ST_OFF)     pu_pend_n = 1'b1;
        end
    end

    // State and latch registers; warning survives supply loss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            warn    <= 1'b0;
            fresh   <= 1'b0;
            pu_pend <= 1'b1;
        end else begin
            state   <= state_n;
            warn    <= warn_n;
            fresh   <= fresh_n;
            pu_pend <= pu_pend_n;
        end
    end

    assign load_en = (state == ST_LOAD);
endmodule

// File: rtl/batt_test_seq.sv
// Top of the periodic loaded battery test sequencer. Ties the shared phase
// timer, the detach-gap watcher and the control FSM together. All intervals
// are clock-cycle counts and each must be at least 1.
module batt_test_seq #(
    parameter int REC_CYC  = 20,
    parameter int LOAD_CYC = 8,
    parameter int NORM_CYC = 200,
    parameter int WARN_CYC = 40,
    parameter int GAP_CYC  = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic batt_low,
    input  logic batt_present,
    output logic load_en,
    output logic warn_pull_en
);
    localparam int M1    = (REC_CYC > LOAD_CYC) ? REC_CYC : LOAD_CYC;
    localparam int M2    = (NORM_CYC > WARN_CYC) ? NORM_CYC : WARN_CYC;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CW    = $clog2(MAXC + 1);

    logic          tmr_start;
    logic [CW-1:0] tmr_len;
    logic          tmr_done;
    logic          reattach_ok;

    bts_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    bts_gap_watch #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk          (clk),
        .rst_n        (rst_n),
        .batt_present (batt_present),
        .reattach_ok  (reattach_ok)
    );

    bts_ctrl #(
        .REC_CYC  (REC_CYC),
        .LOAD_CYC (LOAD_CYC),
        .NORM_CYC (NORM_CYC),
        .WARN_CYC (WARN_CYC),
        .CW       (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .batt_low    (batt_low),
        .reattach_ok (reattach_ok),
        .tmr_done    (tmr_done),
        .tmr_start   (tmr_start),
        .tmr_len     (tmr_len),
        .load_en     (load_en),
        .warn        (warn_pull_en)
    );
endmodule

// File: rtl/batt_test_seq_chk.sv
// Port-level checker for batt_test_seq, bound to every instance.
// Assumes the synchronous active-low reset of the top module.
module batt_test_seq_chk #(
    parameter int LOAD_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic batt_low,
    input logic load_en,
    input logic warn_pull_en
);
    localparam int RW = $clog2(LOAD_CYC + 2);
    logic [RW-1:0] run;

    // Count how many consecutive cycles load_en has already been high
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= '0;
        else if (load_en) run <= run + 1'b1;
        else              run <= '0;
    end

    p_load_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (run < RW'(LOAD_CYC)));

    p_warn_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_pull_en) |-> ($past(load_en) && $past(batt_low) && !load_en));

    p_warn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_pull_en) |-> ($past(load_en) && !$past(batt_low)));

    p_supply_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!load_en && $stable(warn_pull_en)));

    p_load_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en) |-> $past(supply_ok));
endmodule

bind batt_test_seq batt_test_seq_chk #(.LOAD_CYC(LOAD_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .batt_low     (batt_low),
    .load_en      (load_en),
    .warn_pull_en (warn_pull_en)
);

// File: tb/batt_test_seq_test.sv
// Directed bench for batt_test_seq: one task per scenario, each self-checking.
module batt_test_seq_test;
    localparam int REC  = 20;
    localparam int LOAD = 8;
    localparam int NORM = 200;
    localparam int WARN = 40;
    localparam int GAP  = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic batt_low = 1'b0;
    logic batt_present = 1'b1;
    logic load_en;
    logic warn_pull_en;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    batt_test_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .batt_low     (batt_low),
        .batt_present (batt_present),
        .load_en      (load_en),
        .warn_pull_en (warn_pull_en)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Negedges until load_en is seen high (the detecting negedge counts)
    task automatic wait_rise(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            tick();
            n++;
            if (load_en) return;
        end
        n = -1;
    endtask

    // Called on a negedge where load_en is high; returns on the first low one
    task automatic meas_width(output int w);
        w = 1;
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (!load_en) return;
            w++;
        end
    endtask

    // Called on a negedge where load_en is low; counts the low cycles
    task automatic meas_gap(output int g);
        g = 1;
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (load_en) return;
            g++;
        end
    endtask

    // Run one complete test window and return the warning after it
    task automatic run_test(input string tag, output int warn_after);
        int n, w;
        wait_rise(n);
        chk(n > 0, tag, n, 1);
        meas_width(w);
        chk(w == LOAD, {tag, " width"}, w, LOAD);
        warn_after = int'(warn_pull_en);
    endtask

    task automatic t_reset();
        bit seen = 1'b0;
        repeat (3) tick();
        chk(!load_en && !warn_pull_en, "R1 in reset", int'(load_en), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (load_en || warn_pull_en) seen = 1'b1;
        end
        chk(!seen, "R1 idle without supply", int'(seen), 0);
    endtask

    task automatic t_powerup_good();
        int n, w, g;
        supply_ok = 1'b1;
        wait_rise(n);
        chk(n == REC + 1, "R2 power-up delay", n, REC + 1);
        meas_width(w);
        chk(w == LOAD, "R3 load width", w, LOAD);
        chk(!warn_pull_en, "R3 good cell no warning", int'(warn_pull_en), 0);
        meas_gap(g);
        chk(g == NORM, "R5 normal interval", g, NORM);
    endtask

    task automatic t_ignore_between();
        int w, wa;
        meas_width(w);
        // now in the normal interval: glitch comparator and pull the cell
        repeat (5) tick();
        batt_low = 1'b1;
        batt_present = 1'b0;
        repeat (10) tick();
        chk(!warn_pull_en && !load_en, "R11 ignored between tests", int'(warn_pull_en), 0);
        batt_low = 1'b0;
        batt_present = 1'b1;
        run_test("R11 next test", wa);
        chk(wa == 0, "R11 warning stays clear", wa, 0);
    endtask

    task automatic t_bad_cell();
        int wa, g;
        batt_low = 1'b1;
        run_test("R4 bad test", wa);
        chk(wa == 1, "R4 warning set at window end", wa, 1);
        meas_gap(g);
        chk(g == WARN, "R6 warning interval", g, WARN);
    endtask

    task automatic t_sticky();
        int w, wa, g;
        meas_width(w);
        batt_low = 1'b0;
        run_test("R7 passing test", wa);
        chk(wa == 1, "R7 warning held", wa, 1);
        meas_gap(g);
        chk(g == WARN, "R7 still warning interval", g, WARN);
    endtask

    task automatic t_short_detach();
        int w, wa;
        meas_width(w);
        batt_present = 1'b0;
        repeat (GAP - 2) tick();
        batt_present = 1'b1;
        tick();
        chk(!load_en, "R8 short gap no test start", int'(load_en), 0);
        run_test("R8 after short gap", wa);
        chk(wa == 1, "R8 short gap keeps warning", wa, 1);
    endtask

    task automatic t_long_detach();
        int w, g;
        batt_present = 1'b0;
        repeat (GAP + 2) tick();
        batt_present = 1'b1;
        tick();
        chk(load_en, "R8 qualified reattach starts test", int'(load_en), 1);
        meas_width(w);
        chk(w == LOAD, "R8 reattach test width", w, LOAD);
        chk(!warn_pull_en, "R8 warning cleared", int'(warn_pull_en), 1'b0);
        meas_gap(g);
        chk(g == NORM, "R5 back to normal interval", g, NORM);
    endtask

    task automatic t_supply_loss();
        int w, wa, n;
        meas_width(w);
        batt_low = 1'b1;
        run_test("R9 set warning", wa);
        chk(wa == 1, "R9 warning before loss", wa, 1);
        repeat (10) tick();
        supply_ok = 1'b0;
        tick();
        chk(!load_en && warn_pull_en, "R9 warning kept off supply", int'(warn_pull_en), 1);
        repeat (20) tick();
        chk(!load_en && warn_pull_en, "R9 still held", int'(warn_pull_en), 1);
        batt_low = 1'b0;
        supply_ok = 1'b1;
        wait_rise(n);
        chk(n == REC + 1, "R10 power-up delay", n, REC + 1);
        meas_width(w);
        chk(!warn_pull_en, "R10 power-up test clears", int'(warn_pull_en), 0);
    endtask

    task automatic t_collision();
        int n, w;
        batt_low = 1'b1;
        wait_rise(n);
        repeat (LOAD - 1) tick();
        supply_ok = 1'b0;
        tick();
        chk(!load_en, "R9 load dropped at sample edge", int'(load_en), 0);
        chk(!warn_pull_en, "R9 sample discarded", int'(warn_pull_en), 0);
        repeat (5) tick();
        batt_low = 1'b0;
        supply_ok = 1'b1;
        wait_rise(n);
        chk(n == REC + 1, "R2 restart after collision", n, REC + 1);
        meas_width(w);
        chk(!warn_pull_en, "R10 clean power-up test", int'(warn_pull_en), 0);
    endtask

    initial begin
        t_reset();
        t_powerup_good();
        t_ignore_between();
        t_bad_cell();
        t_sticky();
        t_short_detach();
        t_long_detach();
        t_supply_loss();
        t_collision();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule